// File: doc/BRIEF.md
# Either-Edge Pin Interrupt Status Unit

This block watches four general-purpose input pins and records every level change on them, rising or falling, in a sticky status bit per pin. Each pin is first brought into the clock domain through a synchronizer chain. An edge detector then compares the synchronized level with the sample from the cycle before. Software reads the eight-bit status register over a simple write/read strobe interface and clears bits by writing ones. Bits 0 to 3 belong to the pins, bit 4 is a standby-supply power-on flag, and bits 5 to 7 are unused.

A status bit sets whatever the enables say. The per-pin interrupt request only reaches the single registered `irq` output when four things hold together: the bit is set, the pin's enable is set, the pin is in either-edge mode, and the combined enable of the pin's group is on. Pins 0 and 1 form group 0, and pins 2 and 3 form group 1. A per-pin polarity bit inverts only the readable pin level; it never changes which edges are caught. When the system powers up while the power-on flag is set, the unit emits a one-cycle system control interrupt pulse.

Top module: `either_edge_status`

## Requirements
- R1: A rising or a falling transition on pin i (i = 0..3) sets status bit i. This happens whatever the polarity, mode, pin enable and group enable settings are.
- R2: A pin change applied before clock edge k is visible in `rdData` after edge k+2 (two synchronizer flops, then the status register).
- R3: Writing with `wrEn` high clears every status bit whose `wrData` bit is 1. Bits written with 0 keep their value.
- R4: If an edge is detected on a pin in the same cycle as a write-one clear of its bit, the bit stays set.
- R5: `irq` is high one cycle after any pin i has all four of these set: its status bit, `intEn[i]`, `modeSel[i]`, and `grpEn[i/2]`.
- R6: With `modeSel[i]` low, or with the group enable of pin i low, a set status bit i does not raise `irq`.
- R7: `pinLevel[i]` equals the synchronized level of pin i XOR `polarity[i]`.
- R8: A one-cycle `vtrPor` pulse sets status bit 4. Writing 1 to bit 4 clears it, and a set request in the same cycle wins.
- R9: A rising edge on `powerOn` while bit 4 is set gives exactly one cycle of `sciPulse`, on the next clock.
- R10: After reset `rdData` is 00h, `irq` is 0 and `sciPulse` is 0. Bits 7 to 5 of `rdData` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low backup-supply reset, clears everything |
| pinIn | input | 4 | Asynchronous pin levels |
| polarity | input | 4 | Per-pin inversion of the readable level |
| modeSel | input | 4 | Per-pin either-edge mode select |
| intEn | input | 4 | Per-pin interrupt enable |
| grpEn | input | 2 | Combined interrupt enable per group of two pins |
| wrEn | input | 1 | Status register write strobe |
| wrData | input | 8 | Write data, 1 bits clear status |
| rdData | output | 8 | Status register contents |
| vtrPor | input | 1 | Standby-supply power-on reset event pulse |
| powerOn | input | 1 | System power-on level |
| pinLevel | output | 4 | Synchronized pin levels after polarity |
| irq | output | 1 | Registered combined interrupt request |
| sciPulse | output | 1 | One-cycle system control interrupt |

## Verification
The bench hits the falling edge as hard as the rising one, and it runs with polarity bits set. A detector tied to one edge or gated by polarity would leave status bits clear. A clear strobe is timed to land on the exact cycle an edge is detected; a design that lets the clear win would read back 0. The group mapping is probed by enabling the wrong group, so pin 2 firing through group 0 shows up on `irq`. The bench also writes zeros and reserved bits to confirm they touch nothing, and it checks that the power-on pulse lasts a single cycle.

// File: rtl/either_edge_pkg.sv
package either_edge_pkg;
  localparam int NUM_PINS  = 4;
  localparam int GRP_COUNT = 2;
  localparam int REG_W     = 8;
  localparam int POR_BIT   = NUM_PINS;
  localparam int STAT_W    = NUM_PINS + 1;
  localparam int PINS_PER_GRP = NUM_PINS / GRP_COUNT;

  typedef struct packed {
    logic [STAT_W-1:0] clr;
    logic              porSet;
  } strobe_t;
endpackage

// File: rtl/either_edge_ctrl.sv
module either_edge_ctrl
  import either_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              vtrPor,
  input  logic              powerOn,
  input  logic              porFlag,
  output strobe_t           strb,
  output logic              sciPulse
);
  logic powerOnQ;

  always_comb begin
    strb.clr    = wrEn ? wrData[STAT_W-1:0] : '0;
    strb.porSet = vtrPor;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      powerOnQ <= 1'b0;
      sciPulse <= 1'b0;
    end else begin
      powerOnQ <= powerOn;
      sciPulse <= powerOn && !powerOnQ && porFlag;
    end
  end

  AST_SCI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sciPulse |=> !sciPulse); // R9
  AST_SCI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sciPulse) |-> $past(porFlag)); // R9
endmodule

// File: rtl/either_edge_datapath.sv
module either_edge_datapath
  import either_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] polarity,
  input  logic [NUM_PINS-1:0] modeSel,
  input  logic [NUM_PINS-1:0] intEn,
  input  logic [GRP_COUNT-1:0] grpEn,
  input  strobe_t             strb,
  output logic [REG_W-1:0]    status,
  output logic [NUM_PINS-1:0] pinLevel,
  output logic                irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] grpMask;
  logic [NUM_PINS-1:0] pinIrq;
  logic [STAT_W-1:0]   statQ;
  logic [STAT_W-1:0]   setVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign edgeHit  = syncQ[LAST] ^ prevQ;
  assign pinLevel = syncQ[LAST] ^ polarity;
  assign setVec   = {strb.porSet, edgeHit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statQ <= '0;
    else        statQ <= (statQ & ~strb.clr) | setVec;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_grp
    assign grpMask[i] = grpEn[i / PINS_PER_GRP];
  end

  assign pinIrq = statQ[NUM_PINS-1:0] & intEn & modeSel & grpMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |pinIrq;
  end

  assign status = {{(REG_W-STAT_W){1'b0}}, statQ};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      edgeHit[i] |=> statQ[i]); // R1
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.clr[i] && !edgeHit[i]) |=> !statQ[i]); // R3
  end
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clr == '0 && edgeHit == '0 && !strb.porSet) |=> $stable(statQ)); // R3
  AST_POR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    strb.porSet |=> statQ[POR_BIT]); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(statQ[NUM_PINS-1:0] & intEn))); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[REG_W-1:STAT_W] == '0); // R10
endmodule

// File: rtl/either_edge_status.sv
module either_edge_status
  import either_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pinIn,
  input  logic [NUM_PINS-1:0]  polarity,
  input  logic [NUM_PINS-1:0]  modeSel,
  input  logic [NUM_PINS-1:0]  intEn,
  input  logic [GRP_COUNT-1:0] grpEn,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  input  logic                 vtrPor,
  input  logic                 powerOn,
  output logic [NUM_PINS-1:0]  pinLevel,
  output logic                 irq,
  output logic                 sciPulse
);
  strobe_t strb;

  either_edge_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrData(wrData),
    .vtrPor(vtrPor), .powerOn(powerOn), .porFlag(rdData[POR_BIT]),
    .strb(strb), .sciPulse(sciPulse)
  );

  either_edge_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .polarity(polarity),
    .modeSel(modeSel), .intEn(intEn), .grpEn(grpEn), .strb(strb),
    .status(rdData), .pinLevel(pinLevel), .irq(irq)
  );
endmodule

// File: tb/either_edge_status_tb.sv
module either_edge_status_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pinIn = '0, polarity = '0, modeSel = '0, intEn = '0;
  logic [1:0] grpEn = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic vtrPor = 1'b0, powerOn = 1'b0;
  logic [3:0] pinLevel;
  logic irq, sciPulse;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  either_edge_status u_dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .polarity(polarity),
    .modeSel(modeSel), .intEn(intEn), .grpEn(grpEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .vtrPor(vtrPor), .powerOn(powerOn),
    .pinLevel(pinLevel), .irq(irq), .sciPulse(sciPulse)
  );

  // {pins[3:0], clearMask[7:0], expected status[7:0]}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0001, 8'h00, 8'h01},   // R1 rising on pin 0
    {4'b0001, 8'h01, 8'h00},   // R3 clear bit 0
    {4'b0000, 8'h00, 8'h01},   // R1 falling on pin 0
    {4'b1010, 8'h00, 8'h0B},   // R1 pins 1 and 3
    {4'b1010, 8'hF0, 8'h0B},   // R3 zeros and reserved bits do nothing
    {4'b1010, 8'h0A, 8'h01},   // R3 partial clear
    {4'b0101, 8'h00, 8'h0F},   // R1 all four toggle
    {4'b0101, 8'hFF, 8'h00}    // R3 clear all
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);
    chk("R10 reset status", rdData, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
    chk("R10 reset sci", {7'b0, sciPulse}, 8'h00);

    // Table walk: polarity set, mode and enables off, status still latches
    polarity = 4'b0110;
    for (int v = 0; v < NV; v++) begin
      pinIn = VEC[v][19:16];
      waitCyc(4);
      if (VEC[v][15:8] != 8'h00) writeReg(VEC[v][15:8]);
      chk($sformatf("R1/R3 vector %0d", v), rdData, VEC[v][7:0]);
      chk("R6 irq off without enables", {7'b0, irq}, 8'h00);
    end

    // R7: pins now 0101, polarity 0110
    chk("R7 pin level", {4'b0, pinLevel}, 8'h03);

    // R2 latency
    pinIn = 4'b0100;
    waitCyc(2);
    chk("R2 not yet visible", rdData, 8'h00);
    waitCyc(1);
    chk("R2 visible after edge k+2", rdData, 8'h01);
    writeReg(8'h01);

    // R4 collision: bit 1 already set, edge lands with clear
    pinIn = 4'b0110; waitCyc(4);
    chk("R4 setup", rdData, 8'h02);
    pinIn = 4'b0100;
    waitCyc(2);
    writeReg(8'h02);
    chk("R4 edge wins over clear", rdData, 8'h02);
    writeReg(8'h02);
    chk("R3 clear after collision", rdData, 8'h00);

    // R5 / R6 interrupt gating
    intEn = 4'hF; modeSel = 4'hF; grpEn = 2'b01;
    pinIn = 4'b0101; waitCyc(4);
    chk("R5 irq from pin 0", {7'b0, irq}, 8'h01);
    grpEn = 2'b10; waitCyc(1);
    chk("R6 group 0 off blocks pin 0", {7'b0, irq}, 8'h00);
    writeReg(8'h01);
    pinIn = 4'b0001; waitCyc(4);
    chk("R5 pin 2 via group 1", {7'b0, irq}, 8'h01);
    grpEn = 2'b01; waitCyc(1);
    chk("R5 pin 2 not via group 0", {7'b0, irq}, 8'h00);
    grpEn = 2'b10; modeSel = 4'b1011; waitCyc(1);
    chk("R6 mode off blocks pin 2", {7'b0, irq}, 8'h00);
    modeSel = 4'hF; intEn = 4'b1011; waitCyc(1);
    chk("R5 pin enable off", {7'b0, irq}, 8'h00);
    writeReg(8'h04);
    chk("R3 status cleared", rdData, 8'h00);

    // R8 / R9 power-on flag and control interrupt
    powerOn = 1'b1; waitCyc(2);
    chk("R9 no pulse without flag", {7'b0, sciPulse}, 8'h00);
    powerOn = 1'b0;
    vtrPor = 1'b1; @(negedge clk); vtrPor = 1'b0;
    chk("R8 por flag set", rdData, 8'h10);
    powerOn = 1'b1; waitCyc(1);
    chk("R9 pulse on power-on", {7'b0, sciPulse}, 8'h01);
    waitCyc(1);
    chk("R9 pulse one cycle", {7'b0, sciPulse}, 8'h00);
    writeReg(8'hEF);
    chk("R8 zero write keeps flag", rdData, 8'h10);
    vtrPor = 1'b1; writeReg(8'h10); vtrPor = 1'b0;
    chk("R8 set wins over clear", rdData, 8'h10);
    writeReg(8'h10);
    chk("R8 flag cleared", rdData, 8'h00);
    chk("R10 reserved bits zero", {rdData[7:5], 5'b0}, 8'h00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule